// File: doc/BRIEF.md
# ARINC 429 Receive Word Classifier

This block decides the destination of every 32-bit word that any of four serial receive channels assembles. Each channel hands over a finished word, which is held in a one-word slot for that channel. A single scanner serves the slots in rotating order. For each word it walks a 128 x 16 classification table that the host processor loads, one entry per clock, starting at entry 0. The first entry whose label, source/destination and channel tests all pass produces a one-cycle store request. The request carries the word, the table index as receive-RAM address, a FIFO-copy flag and a two-bit interrupt code. A word that no entry accepts is dropped.

The host reaches the table through a write port and a registered read port. A table write is held off while a scan runs, so every scan sees one fixed table. Each channel has its own all-call enable. The reset is asynchronous and active low, and the surrounding chip releases it synchronously to `clk`.

Word fields used: label = word bits 7:0, source/destination (S/D) = word bits 9:8. Table entry fields: bits 7:0 label, bits 9:8 S/D, bit 10 S/D don't-care, bit 11 FIFO copy, bits 13:12 channel number, bits 15:14 interrupt select (00 = none).

Top module: `a429_match_engine`

## Requirements
- R1: A word on channel c is taken into its slot at a rising edge where `ch_valid[c]`=1 and `ch_busy[c]`=0. `ch_busy[c]` is 1 from the next cycle until that word's scan ends. `ch_valid[c]` while `ch_busy[c]`=1 is ignored, and the original word is still the one reported.
- R2: The label test passes when entry bits 7:0 equal word bits 7:0, or when entry bits 7:0 are zero (wildcard).
- R3: The S/D test passes when entry bits 9:8 equal word bits 9:8, or when entry bit 10 is 1.
- R4: With `allcall_en[c]`=1, a word from channel c whose bits 9:8 are 00 passes the S/D test for every entry. With `allcall_en[c]`=0 it does not.
- R5: The channel test passes only when entry bits 13:12 equal the receiving channel number (0 to 3).
- R6: The request reports the lowest-indexed entry that passes all three tests, with `req_addr` equal to that index. It is a one-cycle `req_valid` pulse, registered at the (k+2)-th rising edge after the capture edge when entry k hits, if no other scan is pending. `ch_busy` falls at the same edge.
- R7: A request carries `req_word` = the captured word, `req_ch` = the receiving channel, `req_fifo` = entry bit 11 and `req_irq` = entry bits 15:14.
- R8: A word that passes no entry produces no request, and `ch_busy` falls at the 129th rising edge after the capture edge.
- R9: When several slots are waiting, scans are granted in rotating channel order, each next channel being the one after the last one served.
- R10: `host_wait` is 1 while a scan runs. A host write to the table takes effect only at an edge where `host_wait` is 0, so a write issued during a scan does not affect that scan.
- R11: `host_rdata` shows the table entry at `host_addr` one rising edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 4 | Per-channel word-ready strobe |
| ch_word | input | 128 | Per-channel words, channel c at bits 32c+31:32c |
| allcall_en | input | 4 | Per-channel all-call enable |
| ch_busy | output | 4 | Per-channel slot occupied |
| host_wr | input | 1 | Host table write request (hold until accepted) |
| host_addr | input | 7 | Host table address for write and read |
| host_wdata | input | 16 | Host table write data |
| host_rdata | output | 16 | Registered host table read data |
| host_wait | output | 1 | Scan in progress; host writes held off |
| req_valid | output | 1 | Store request strobe |
| req_word | output | 32 | Word to store |
| req_addr | output | 7 | Receive-RAM address (matching entry index) |
| req_ch | output | 2 | Receiving channel |
| req_fifo | output | 1 | Also copy the word into the channel FIFO |
| req_irq | output | 2 | Interrupt select, 00 = none |

## Verification
A lone word captured at edge 0 that first hits entry k makes `req_valid` show at edge k+2, and a missed word releases `ch_busy` at edge 129. The bench counts rising edges from the capture edge and compares the count with these figures, sampling 1 ns after each edge. Host reads are sampled one edge after the address, and write hold-off is judged by `host_wait` at the falling edge before the accepting edge. When several channels contend, the bench compares only the order and content of the requests, because those results come later than the single-channel figures.

// File: rtl/a429_me_pkg.sv
package a429_me_pkg;

  typedef struct packed {
    logic [1:0] irq;     // 15:14
    logic [1:0] chan;    // 13:12
    logic       fifo;    // 11
    logic       sd_any;  // 10
    logic [1:0] sd;      // 9:8
    logic [7:0] label;   // 7:0
  } entry_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_t;

  function automatic logic entry_hit(entry_t e, logic [7:0] lbl, logic [1:0] sd,
                                     logic [1:0] ch, logic allcall);
    logic lbl_ok, sd_ok, ch_ok;
    lbl_ok = (e.label == 8'h00) || (e.label == lbl);
    sd_ok  = e.sd_any || (e.sd == sd) || (allcall && (sd == 2'b00));
    ch_ok  = (e.chan == ch);
    return lbl_ok && sd_ok && ch_ok;
  endfunction

endpackage

// File: rtl/a429_me_table.sv
module a429_me_table #(
  parameter int N_ENT = 128,
  parameter int ENT_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ENT_W-1:0] rd_data,
  input  logic [IDX_W-1:0] scan_idx,
  output logic [ENT_W-1:0] scan_entry
);

  logic [ENT_W-1:0] mem [N_ENT];
  logic [ENT_W-1:0] rd_q;

  // storage array: no reset, written only when enabled
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end

  assign rd_data    = rd_q;
  assign scan_entry = mem[scan_idx];

endmodule

// File: rtl/a429_me_slots.sv
module a429_me_slots #(
  parameter int N_CH   = 4,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          in_valid,
  input  logic [N_CH*WORD_W-1:0]   in_word,
  input  logic [N_CH-1:0]          clr,
  output logic [N_CH-1:0]          full,
  output logic [WORD_W-1:0]        word [N_CH]
);

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    logic              full_q, full_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic              load;

    always_comb begin
      load   = in_valid[g] && !full_q;
      full_d = full_q;
      word_d = word_q;
      if (load) begin
        full_d = 1'b1;
        word_d = in_word[g*WORD_W +: WORD_W];
      end else if (clr[g]) begin
        full_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        word_q <= '0;
      end else begin
        full_q <= full_d;
        word_q <= word_d;
      end
    end

    assign full[g] = full_q;
    assign word[g] = word_q;
  end

endmodule

// File: rtl/a429_me_arb.sv
module a429_me_arb #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic            take,
  output logic            any,
  output logic [CH_W-1:0] gnt_idx
);

  logic [CH_W-1:0] last_q, last_d;
  logic            found;

  always_comb begin
    found   = 1'b0;
    gnt_idx = '0;
    for (int off = 1; off <= N_CH; off++) begin
      int c;
      c = (int'(last_q) + off) % N_CH;
      if (!found && req[c]) begin
        found   = 1'b1;
        gnt_idx = CH_W'(c);
      end
    end
    any    = found;
    last_d = (take && found) ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CH_W'(N_CH - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/a429_me_scan.sv
module a429_me_scan
  import a429_me_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int N_ENT  = 128,
  parameter int WORD_W = 32,
  parameter int ENT_W  = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend,
  input  logic [CH_W-1:0]   gnt_idx,
  input  logic [WORD_W-1:0] pend_word [N_CH],
  input  logic [N_CH-1:0]   allcall_en,
  output logic              idle,
  output logic [N_CH-1:0]   clr,
  output logic [IDX_W-1:0]  scan_idx,
  input  logic [ENT_W-1:0]  scan_entry,
  output logic              req_valid,
  output logic [WORD_W-1:0] req_word,
  output logic [IDX_W-1:0]  req_addr,
  output logic [CH_W-1:0]   req_ch,
  output logic              req_fifo,
  output logic [1:0]        req_irq
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  scan_st_t          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [WORD_W-1:0] w_q, w_d;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] rw_q, rw_d;
  logic [IDX_W-1:0]  ra_q, ra_d;
  logic [CH_W-1:0]   rc_q, rc_d;
  logic              rf_q, rf_d;
  logic [1:0]        ri_q, ri_d;
  entry_t            ent;
  logic              hit, done;

  assign ent = entry_t'(scan_entry);
  assign hit = (st_q == ST_SCAN) &&
               entry_hit(ent, w_q[7:0], w_q[9:8], 2'(ch_q), allcall_en[ch_q]);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ch_d  = ch_q;
    w_d   = w_q;
    rv_d  = 1'b0;
    rw_d  = rw_q;
    ra_d  = ra_q;
    rc_d  = rc_q;
    rf_d  = rf_q;
    ri_d  = ri_q;
    done  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (any_pend) begin
          st_d  = ST_SCAN;
          idx_d = '0;
          ch_d  = gnt_idx;
          w_d   = pend_word[gnt_idx];
        end
      end
      default: begin
        if (hit || (idx_q == LAST)) begin
          st_d = ST_IDLE;
          done = 1'b1;
          if (hit) begin
            rv_d = 1'b1;
            rw_d = w_q;
            ra_d = idx_q;
            rc_d = ch_q;
            rf_d = ent.fifo;
            ri_d = ent.irq;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      ch_q  <= '0;
      w_q   <= '0;
      rv_q  <= 1'b0;
      rw_q  <= '0;
      ra_q  <= '0;
      rc_q  <= '0;
      rf_q  <= 1'b0;
      ri_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ch_q  <= ch_d;
      w_q   <= w_d;
      rv_q  <= rv_d;
      rw_q  <= rw_d;
      ra_q  <= ra_d;
      rc_q  <= rc_d;
      rf_q  <= rf_d;
      ri_q  <= ri_d;
    end
  end

  always_comb begin
    clr = '0;
    if (done) clr[ch_q] = 1'b1;
  end

  assign idle      = (st_q == ST_IDLE);
  assign scan_idx  = idx_q;
  assign req_valid = rv_q;
  assign req_word  = rw_q;
  assign req_addr  = ra_q;
  assign req_ch    = rc_q;
  assign req_fifo  = rf_q;
  assign req_irq   = ri_q;

endmodule

// File: rtl/a429_match_engine.sv
module a429_match_engine #(
  parameter int N_CH   = 4,
  parameter int N_ENT  = 128,
  parameter int WORD_W = 32,
  parameter int ENT_W  = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        ch_valid,
  input  logic [N_CH*WORD_W-1:0] ch_word,
  input  logic [N_CH-1:0]        allcall_en,
  output logic [N_CH-1:0]        ch_busy,
  input  logic                   host_wr,
  input  logic [IDX_W-1:0]       host_addr,
  input  logic [ENT_W-1:0]       host_wdata,
  output logic [ENT_W-1:0]       host_rdata,
  output logic                   host_wait,
  output logic                   req_valid,
  output logic [WORD_W-1:0]      req_word,
  output logic [IDX_W-1:0]       req_addr,
  output logic [CH_W-1:0]        req_ch,
  output logic                   req_fifo,
  output logic [1:0]             req_irq
);

  logic [N_CH-1:0]   full, clr;
  logic [WORD_W-1:0] slot_word [N_CH];
  logic              any_pend, idle, tbl_we;
  logic [CH_W-1:0]   gnt_idx;
  logic [IDX_W-1:0]  scan_idx;
  logic [ENT_W-1:0]  scan_entry;

  assign tbl_we    = host_wr && idle;
  assign host_wait = !idle;
  assign ch_busy   = full;

  a429_me_table #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(host_addr), .wr_data(host_wdata),
    .rd_addr(host_addr), .rd_data(host_rdata),
    .scan_idx(scan_idx), .scan_entry(scan_entry)
  );

  a429_me_slots #(.N_CH(N_CH), .WORD_W(WORD_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ch_valid), .in_word(ch_word), .clr(clr),
    .full(full), .word(slot_word)
  );

  a429_me_arb #(.N_CH(N_CH)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(full), .take(idle), .any(any_pend), .gnt_idx(gnt_idx)
  );

  a429_me_scan #(.N_CH(N_CH), .N_ENT(N_ENT), .WORD_W(WORD_W), .ENT_W(ENT_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .any_pend(any_pend), .gnt_idx(gnt_idx), .pend_word(slot_word),
    .allcall_en(allcall_en), .idle(idle), .clr(clr),
    .scan_idx(scan_idx), .scan_entry(scan_entry),
    .req_valid(req_valid), .req_word(req_word), .req_addr(req_addr),
    .req_ch(req_ch), .req_fifo(req_fifo), .req_irq(req_irq)
  );

endmodule

// File: rtl/a429_me_chk.sv
module a429_me_chk #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] ch_valid,
  input logic [N_CH-1:0] ch_busy,
  input logic            host_wait,
  input logic            req_valid,
  input logic [CH_W-1:0] req_ch
);

  logic [N_CH-1:0] busy_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_prev <= '0;
    else        busy_prev <= ch_busy;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_cap
    // R1
    capture_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid[g] && !ch_busy[g]) |=> ch_busy[g]);
  end

  // R6
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6
  req_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!ch_busy[req_ch] && busy_prev[req_ch]));

  // R10
  req_ends_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(host_wait) && !host_wait));

endmodule

bind a429_match_engine a429_me_chk #(.N_CH(N_CH)) u_me_chk (
  .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_busy(ch_busy),
  .host_wait(host_wait), .req_valid(req_valid), .req_ch(req_ch)
);

// File: tb/test_a429_match_engine.sv
`timescale 1ns/1ps
module test_a429_match_engine;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   ch_valid;
  logic [127:0] ch_word;
  logic [3:0]   allcall_en;
  logic [3:0]   ch_busy;
  logic         host_wr;
  logic [6:0]   host_addr;
  logic [15:0]  host_wdata;
  logic [15:0]  host_rdata;
  logic         host_wait;
  logic         req_valid;
  logic [31:0]  req_word;
  logic [6:0]   req_addr;
  logic [1:0]   req_ch;
  logic         req_fifo;
  logic [1:0]   req_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [15:0] tbl [128];
  localparam logic [15:0] NULL_ENT = 16'h00FF;  // label FF, never used by words

  always #5 clk = ~clk;

  a429_match_engine i_a429_match_engine (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_word(ch_word),
    .allcall_en(allcall_en), .ch_busy(ch_busy), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .req_valid(req_valid), .req_word(req_word),
    .req_addr(req_addr), .req_ch(req_ch), .req_fifo(req_fifo), .req_irq(req_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_match(logic [31:0] w, int ch, logic ac);
    for (int i = 0; i < 128; i++) begin
      logic [15:0] e;
      bit l_ok, s_ok, c_ok;
      e    = tbl[i];
      l_ok = (e[7:0] == 8'h00) || (e[7:0] == w[7:0]);
      s_ok = e[10] || (e[9:8] == w[9:8]) || (ac && w[9:8] == 2'b00);
      c_ok = (int'(e[13:12]) == ch);
      if (l_ok && s_ok && c_ok) return i;
    end
    return -1;
  endfunction

  task automatic wr_entry(input int idx, input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 7'(idx); host_wdata = v;
    while (host_wait) @(negedge clk);
    @(posedge clk); #1;
    host_wr = 1'b0;
    tbl[idx] = v;
  endtask

  task automatic rd_check(input int idx, input string tag);
    @(negedge clk);
    host_addr = 7'(idx);
    @(posedge clk); #1;
    chk(host_rdata == tbl[idx], tag, 64'(host_rdata), 64'(tbl[idx]));
  endtask

  task automatic null_table();
    for (int i = 0; i < 128; i++) wr_entry(i, NULL_ENT);
  endtask

  // exp_idx: -2 = take from reference model, otherwise the directed expectation
  task automatic check_word(input int ch, input logic [31:0] w, input int exp_idx,
                            input bit inject, input string tag);
    int exp, n, got_n, got_a;
    logic [31:0] got_w;
    logic [1:0] got_c, got_i;
    logic got_f;
    exp = (exp_idx == -2) ? ref_match(w, ch, allcall_en[ch]) : exp_idx;
    @(negedge clk);
    ch_valid[ch] = 1'b1;
    ch_word[ch*32 +: 32] = w;
    @(posedge clk); #1;
    ch_valid[ch] = 1'b0;
    chk(ch_busy[ch] == 1'b1, {tag, " R1 busy after capture"}, 64'(ch_busy[ch]), 1);
    n = 0; got_n = -1; got_a = 0; got_w = '0; got_c = '0; got_i = '0; got_f = 1'b0;
    while (n < 200) begin
      @(posedge clk); n++; #1;
      if (inject && n == 1) begin
        ch_valid[ch] = 1'b1;
        ch_word[ch*32 +: 32] = ~w;
      end
      if (inject && n == 2) ch_valid[ch] = 1'b0;
      if (req_valid && got_n < 0) begin
        got_n = n; got_a = int'(req_addr); got_w = req_word;
        got_c = req_ch; got_i = req_irq; got_f = req_fifo;
      end
      if (!ch_busy[ch]) break;
    end
    if (exp >= 0) begin
      chk(got_n == exp + 2, {tag, " R6 latency"}, 64'(got_n), 64'(exp + 2));
      chk(got_a == exp, {tag, " R6 first-hit index"}, 64'(got_a), 64'(exp));
      chk(got_w == w && int'(got_c) == ch, {tag, " R7 word/channel"},
          {got_w, 30'd0, got_c}, {w, 30'd0, 2'(ch)});
      chk(got_f == tbl[exp][11] && got_i == tbl[exp][15:14], {tag, " R7 fifo/irq"},
          64'({got_f, got_i}), 64'({tbl[exp][11], tbl[exp][15:14]}));
    end else begin
      chk(got_n < 0, {tag, " R8 no request"}, 64'(got_n), 64'(-1));
      chk(n == 129, {tag, " R8 busy release"}, 64'(n), 129);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int order [4];
    int nreq, seen_req;
    void'($urandom(32'h429A));
    rst_n = 1'b0; ch_valid = '0; ch_word = '0; allcall_en = '0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(ch_busy == 4'h0 && !req_valid && !host_wait, "R1 reset state",
        64'({ch_busy, req_valid, host_wait}), 0);
    @(negedge clk); rst_n = 1'b1;

    null_table();
    // R11 readback of host-written entries
    wr_entry(17, 16'hA5C3);
    rd_check(17, "R11 readback 17");
    rd_check(0, "R11 readback 0");

    // R2 wildcard label, R5 channel, R1 ignored strobe while busy
    wr_entry(17, NULL_ENT);
    wr_entry(5, {2'b10, 2'd2, 1'b1, 1'b1, 2'b00, 8'h00});
    check_word(2, 32'h1234_0133, 5, 1'b1, "R2 wildcard ch2 (R1 inject)");
    check_word(1, 32'h1234_0133, -1, 1'b0, "R5 other channel");

    // R2 exact label, R3 S/D compare, R6 first hit
    wr_entry(3, {2'b01, 2'd1, 1'b0, 1'b0, 2'b10, 8'h41});
    wr_entry(4, {2'b11, 2'd1, 1'b1, 1'b1, 2'b00, 8'h41});
    check_word(1, 32'h0000_0241, 3, 1'b0, "R6 lowest of two hits");
    check_word(1, 32'h0000_0141, 4, 1'b0, "R3 S/D ignore bit");
    check_word(1, 32'h0000_0242, -1, 1'b0, "R2 label mismatch");
    wr_entry(4, NULL_ENT);
    check_word(1, 32'h0000_0141, -1, 1'b0, "R3 S/D mismatch");

    // R4 all-call
    check_word(1, 32'h0000_0041, -1, 1'b0, "R4 all-call off");
    allcall_en = 4'b0001;
    check_word(1, 32'h0000_0041, -1, 1'b0, "R4 all-call other channel");
    allcall_en = 4'b0010;
    check_word(1, 32'h0000_0041, 3, 1'b0, "R4 all-call on");
    allcall_en = 4'b0000;

    // R9 rotating service of four waiting slots
    null_table();
    for (int c = 0; c < 4; c++) wr_entry(c, {2'b00, 2'(c), 1'b0, 1'b1, 2'b00, 8'h00});
    @(negedge clk);
    ch_valid = 4'hF;
    for (int c = 0; c < 4; c++) ch_word[c*32 +: 32] = 32'hC0DE_0000 + 32'(c);
    @(posedge clk); #1; ch_valid = '0;
    nreq = 0;
    for (int t = 0; t < 40; t++) begin
      @(posedge clk); #1;
      if (req_valid && nreq < 4) begin
        order[nreq] = int'(req_ch);
        chk(req_word == 32'hC0DE_0000 + 32'(req_ch) && int'(req_addr) == int'(req_ch),
            "R9 contended request content", 64'({req_word, 25'd0, req_addr}),
            64'({32'hC0DE_0000 + 32'(req_ch), 25'd0, 7'(req_ch)}));
        nreq++;
      end
    end
    chk(nreq == 4, "R9 request count", 64'(nreq), 4);
    for (int i = 1; i < 4; i++)
      chk(order[i] == (order[i-1] + 1) % 4, "R9 rotation order", 64'(order[i]),
          64'((order[i-1] + 1) % 4));

    // R10 write held off during a scan
    null_table();
    @(negedge clk);
    ch_valid[0] = 1'b1; ch_word[31:0] = 32'h0000_0055;
    @(posedge clk); #1; ch_valid[0] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(host_wait == 1'b1, "R10 wait during scan", 64'(host_wait), 1);
    host_wr = 1'b1; host_addr = 7'd100; host_wdata = {2'b00, 2'd0, 1'b0, 1'b1, 2'b00, 8'h00};
    seen_req = 0;
    while (host_wait) begin
      @(negedge clk);
      if (req_valid) seen_req++;
    end
    @(posedge clk); #1; host_wr = 1'b0;
    tbl[100] = host_wdata;
    chk(seen_req == 0, "R10 running scan unaffected", 64'(seen_req), 0);
    rd_check(100, "R10 held write landed");
    check_word(0, 32'h0000_0055, 100, 1'b0, "R10 later scan uses write");

    // random table and traffic against the reference model
    for (int i = 0; i < 128; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      v[7:0] = 8'($urandom_range(0, 7));
      if (v[7:0] == 0 && ($urandom % 4) != 0) v[7:0] = 8'h03;
      v[10] = (($urandom % 4) == 0);
      wr_entry(i, v);
    end
    for (int k = 0; k < 150; k++) begin
      logic [31:0] w;
      int ch;
      w = $urandom;
      w[7:0] = 8'($urandom_range(1, 9));
      ch = $urandom_range(0, 3);
      allcall_en = 4'($urandom);
      check_word(ch, w, -2, 1'b0, "R6 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule